// File: doc/BRIEF.md
# Register Bridge with Deferred Reads

This block stands between the register command side of a serial control port and a slower internal memory bus. Each command carries a 16-bit address. Addresses below 0x1000 are served at once by a small local register file. Addresses from 0x1000 up go across the bridge to a memory bus with variable latency.

A bridged read whose data comes back within a fixed response window is answered directly with that data. If the data is late, the command is answered with a response code chosen by software. The fetch then finishes in the background, and its data is held. Software collects it by reading the same address again, or by reading the held-data register.

The commander issues one command and waits for its response before it issues the next. A status register shows the bridge's progress. A sticky interrupt flag marks late reads.

Top module: `defer_read_bridge`

## Requirements
- R1: A command at an address below 0x1000 is answered one cycle after it is accepted, with code OK (00) and no memory request. Local register offsets are decoded from address bits 11:0: status 0xD0, control 0xD1, last-read address low byte 0xD2, last-read address high byte 0xD3, held read data 0xD4, interrupt flag 0xD5 (bit 0). Every other local offset reads as 0.
- R2: After reset the status register reads 0x00, the control register reads 0x01 and irq_late is 0. Status bits 7:4 always read as 0.
- R3: Status bit 2 (busy) is 1 from the acceptance of a bridged read or write until its memory acknowledge, and 0 otherwise.
- R4: Status bit 1 (done) is set when a bridged access is acknowledged. It is cleared when the next bridged access is accepted, including a read that is served from held data.
- R5: Status bit 0 (ready) is set when a bridged read is acknowledged and its data is held in register 0xD4. It is cleared when any later bridged read is accepted.
- R6: A bridged read to the address held in 0xD2/0xD3, issued while ready is 1, returns the held data with code OK one cycle later and starts no memory request. A read to any other address starts a new fetch.
- R7: A bridged read acknowledged on any of the first WINDOW clock edges after acceptance is answered with the fetched data and code OK on that same edge.
- R8: If no acknowledge arrives within WINDOW edges, the read is answered on edge WINDOW with data 0 and a code that depends on control bits 1:0: 00 gives IGNORED (01), 01 gives OK (00), 10 gives FAIL (10). The fetch then completes in the background.
- R9: Writing 11 to control bits 1:0 stores 01.
- R10: Status bit 3 (late) is set together with a late answer and is cleared when the next bridged access is accepted. The same event sets the interrupt flag, which drives irq_late. The flag stays set until 1 is written to bit 0 of offset 0xD5. Writing 0 to that bit leaves it set.
- R11: A bridged read or write issued while a background access is still outstanding is answered one cycle later with FAIL (10). It starts no memory request.
- R12: A bridged write is answered with OK one cycle after acceptance. It issues a memory request with mem_we=1 and the command's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 2 | 00 OK, 01 IGNORED, 10 FAIL |
| rsp_rdata | output | 8 | Read data of the response |
| mem_req | output | 1 | Memory request, held high until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| irq_late | output | 1 | Sticky late-read interrupt flag |

## Verification
The hardest situation to reach is the background phase: a late read has been answered, but its fetch is still outstanding. Local status polls must still work in that phase, while bridged commands must be refused. The held data must later be collectable without a second fetch. The bench's memory model has a latency that each test sets, well beyond the window. The bench then polls status, sends bridged commands into the busy bridge, and finally re-reads the same address while it counts memory requests. Latencies of exactly WINDOW and WINDOW+1 cycles probe the edge of the deadline.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 12;

  typedef enum logic [1:0] {
    RSP_OK   = 2'b00,
    RSP_IGN  = 2'b01,
    RSP_FAIL = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RDWIN,
    S_RDBG,
    S_WRBG
  } st_e;

  localparam logic [OFF_W-1:0] OFF_STAT = 12'h0D0;
  localparam logic [OFF_W-1:0] OFF_CTL  = 12'h0D1;
  localparam logic [OFF_W-1:0] OFF_LALO = 12'h0D2;
  localparam logic [OFF_W-1:0] OFF_LAHI = 12'h0D3;
  localparam logic [OFF_W-1:0] OFF_RDAT = 12'h0D4;
  localparam logic [OFF_W-1:0] OFF_IRQ  = 12'h0D5;

  function automatic logic [1:0] late_code(input logic [1:0] sel);
    case (sel)
      2'b00:   late_code = RSP_IGN;
      2'b10:   late_code = RSP_FAIL;
      default: late_code = RSP_OK;
    endcase
  endfunction
endpackage

// File: rtl/brg_decode.sv
module brg_decode
  import brg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BRIDGE_BASE = 16'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_br,
  output logic [OFF_W-1:0]  off
);
  always_comb begin
    is_br = (addr >= BRIDGE_BASE);
    off   = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/brg_window.sv
module brg_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = (WINDOW < 2) ? 1 : $clog2(WINDOW);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    expire = run && (cnt_q == CW'(WINDOW - 1));
    cnt_en = start || run;
    cnt_n  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/brg_regs.sv
module brg_regs
  import brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] hold,
  input  logic              late_set,
  output logic [1:0]        ctl,
  output logic              irq,
  output logic [DATA_W-1:0] rd_val
);
  logic [1:0] ctl_n;
  logic       ctl_en, irq_n, irq_en;

  always_comb begin
    ctl_en = wr_en && (off == OFF_CTL);
    ctl_n  = (wdata[1:0] == 2'b11) ? 2'b01 : wdata[1:0];
    irq_en = late_set || (wr_en && (off == OFF_IRQ) && wdata[0]);
    irq_n  = late_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= 2'b01;
      irq <= 1'b0;
    end else begin
      if (ctl_en) ctl <= ctl_n;
      if (irq_en) irq <= irq_n;
    end
  end

  always_comb begin
    case (off)
      OFF_STAT: rd_val = status;
      OFF_CTL:  rd_val = {{(DATA_W-2){1'b0}}, ctl};
      OFF_LALO: rd_val = last_addr[7:0];
      OFF_LAHI: rd_val = last_addr[15:8];
      OFF_RDAT: rd_val = hold;
      OFF_IRQ:  rd_val = {{(DATA_W-1){1'b0}}, irq};
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/defer_read_bridge.sv
module defer_read_bridge
  import brg_pkg::*;
#(
  parameter int                WINDOW      = 4,
  parameter logic [ADDR_W-1:0] BRIDGE_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq_late
);
  st_e state_q, state_n;

  logic              is_br;
  logic [OFF_W-1:0]  off;
  logic              acc, local_cmd, br_cmd, busy_fail, br_go, held, fetch, wr_go;
  logic              rd_open, ack_rd, direct, expire, late_now;
  logic              late_q, done_q, rdy_q;
  logic [ADDR_W-1:0] last_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] status, reg_val;
  logic [1:0]        ctl;
  logic              rsp_valid_n;
  logic [1:0]        rsp_code_n;
  logic [DATA_W-1:0] rsp_rdata_n;
  logic              mreq_n, mload;

  brg_decode #(.BRIDGE_BASE(BRIDGE_BASE)) u_dec (
    .addr (cmd_addr),
    .is_br(is_br),
    .off  (off)
  );

  brg_window #(.WINDOW(WINDOW)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fetch),
    .run   (rd_open && !mem_ack),
    .expire(expire)
  );

  brg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (local_cmd && cmd_write),
    .off      (off),
    .wdata    (cmd_wdata),
    .status   (status),
    .last_addr(last_q),
    .hold     (hold_q),
    .late_set (late_now),
    .ctl      (ctl),
    .irq      (irq_late),
    .rd_val   (reg_val)
  );

  // command classification
  always_comb begin
    rd_open   = (state_q == S_RDWIN);
    acc       = cmd_valid && !rd_open;
    local_cmd = acc && !is_br;
    br_cmd    = acc && is_br;
    busy_fail = br_cmd && (state_q != S_IDLE);
    br_go     = br_cmd && (state_q == S_IDLE);
    held      = br_go && !cmd_write && rdy_q && (cmd_addr == last_q);
    fetch     = br_go && !cmd_write && !held;
    wr_go     = br_go && cmd_write;
    ack_rd    = mem_ack && ((state_q == S_RDWIN) || (state_q == S_RDBG));
    direct    = rd_open && mem_ack;
    late_now  = rd_open && !mem_ack && expire;
    status    = {4'b0000, late_q, (state_q != S_IDLE), done_q, rdy_q};
  end

  // next state
  always_comb begin
    state_n = state_q;
    case (state_q)
      S_IDLE: begin
        if (fetch)      state_n = S_RDWIN;
        else if (wr_go) state_n = S_WRBG;
      end
      S_RDWIN: begin
        if (mem_ack)       state_n = S_IDLE;
        else if (late_now) state_n = S_RDBG;
      end
      S_RDBG:  if (mem_ack) state_n = S_IDLE;
      S_WRBG:  if (mem_ack) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  // response selection
  always_comb begin
    rsp_valid_n = local_cmd || busy_fail || held || wr_go || direct || late_now;
    rsp_code_n  = RSP_OK;
    rsp_rdata_n = '0;
    if (busy_fail)     rsp_code_n = RSP_FAIL;
    else if (late_now) rsp_code_n = late_code(ctl);
    if (local_cmd && !cmd_write) rsp_rdata_n = reg_val;
    else if (held)               rsp_rdata_n = hold_q;
    else if (direct)             rsp_rdata_n = mem_rdata;
    mload  = fetch || wr_go;
    mreq_n = mload || (mem_req && !mem_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_OK;
      rsp_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      late_q    <= 1'b0;
      done_q    <= 1'b0;
      rdy_q     <= 1'b0;
      last_q    <= '0;
      hold_q    <= '0;
    end else begin
      state_q   <= state_n;
      rsp_valid <= rsp_valid_n;
      if (rsp_valid_n) begin
        rsp_code  <= rsp_code_n;
        rsp_rdata <= rsp_rdata_n;
      end
      mem_req <= mreq_n;
      if (mload) begin
        mem_we    <= cmd_write;
        mem_addr  <= cmd_addr;
        mem_wdata <= cmd_wdata;
      end
      if (late_now)   late_q <= 1'b1;
      else if (br_go) late_q <= 1'b0;
      if (mem_ack && (state_q != S_IDLE)) done_q <= 1'b1;
      else if (br_go)                     done_q <= 1'b0;
      if (ack_rd)                    rdy_q <= 1'b1;
      else if (br_go && !cmd_write)  rdy_q <= 1'b0;
      if (fetch)  last_q <= cmd_addr;
      if (ack_rd) hold_q <= mem_rdata;
    end
  end
endmodule

// File: rtl/brg_chk.sv
module brg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_write,
  input logic        cmd_is_br,
  input logic [15:0] cmd_addr,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        rsp_valid,
  input logic [1:0]  rsp_code,
  input logic        irq_late,
  input logic [7:0]  status,
  input logic [15:0] last_addr,
  input logic        rd_open
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'b0000);

  a_r3_busy_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> status[2]);

  a_r1_req_from_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cmd_valid && cmd_is_br));

  a_r11_busy_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_is_br && status[2] && !rd_open) |=> (rsp_valid && rsp_code == 2'b10));

  a_r6_held_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_is_br && !status[2] && status[0] && cmd_addr == last_addr)
      |=> (!mem_req && rsp_valid && rsp_code == 2'b00));

  a_r10_irq_follows_late: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> irq_late);

  a_r4_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> status[1]);
endmodule

bind defer_read_bridge brg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_write(cmd_write),
  .cmd_is_br(is_br),
  .cmd_addr (cmd_addr),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .rsp_valid(rsp_valid),
  .rsp_code (rsp_code),
  .irq_late (irq_late),
  .status   (status),
  .last_addr(last_q),
  .rd_open  (rd_open)
);

// File: tb/sim_defer_read_bridge.sv
`timescale 1ns/1ps
module sim_defer_read_bridge;
  localparam int WIN = 4;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_write;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [7:0]  rsp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        irq_late;

  int total, bad;
  int mem_lat, mem_starts;
  logic        seen_we;
  logic [15:0] seen_addr;
  logic [7:0]  seen_wdata;

  defer_read_bridge #(.WINDOW(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_late(irq_late)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  // memory model: acknowledge mem_lat edges after the request is raised
  initial begin
    mem_ack = 1'b0; mem_rdata = 8'h00; mem_starts = 0;
    seen_we = 1'b0; seen_addr = 16'h0; seen_wdata = 8'h0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && !mem_ack) begin
        mem_starts++;
        seen_we = mem_we; seen_addr = mem_addr; seen_wdata = mem_wdata;
        repeat (mem_lat - 1) @(negedge clk);
        mem_rdata = mem_val(mem_addr);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic w, input logic [15:0] a, input logic [7:0] d,
                     output logic [1:0] c, output logic [7:0] q);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    c = rsp_code; q = rsp_rdata;
    if (!rsp_valid) begin
      c = 2'bxx; q = 8'hxx;
    end
  endtask

  task automatic rd_local(input logic [15:0] a, output logic [7:0] q);
    logic [1:0] c;
    cmd(1'b0, a, 8'h00, c, q);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n;
    n = 0;
    rd_local(16'h00D0, s);
    while (s[2] && n < 200) begin
      rd_local(16'h00D0, s);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R2 irq after reset", irq_late, 0);
    chk("R2 mem_req after reset", mem_req, 0);
    rd_local(16'h00D0, q); chk("R2 status reset", q, 8'h00);
    rd_local(16'h00D1, q); chk("R2 control reset", q, 8'h01);
  endtask

  task automatic t_local();
    logic [1:0] c; logic [7:0] q; int s0;
    s0 = mem_starts;
    cmd(1'b0, 16'h0FFF, 8'h00, c, q);
    chk("R1 local code", c, 2'b00); chk("R1 unknown local reads 0", q, 8'h00);
    cmd(1'b1, 16'h0010, 8'h5A, c, q);
    chk("R1 local write code", c, 2'b00);
    repeat (3) @(negedge clk);
    chk("R1 no memory request", mem_starts, s0);
  endtask

  task automatic t_direct();
    logic [1:0] c; logic [7:0] q;
    mem_lat = 2;
    cmd(1'b0, 16'h1234, 8'h00, c, q);
    chk("R7 direct code", c, 2'b00); chk("R7 direct data", q, 8'h91);
    rd_local(16'h00D0, q); chk("R4 R5 status after direct", q, 8'h03);
    mem_lat = 1;
    cmd(1'b0, 16'h1000, 8'h00, c, q);
    chk("R1 0x1000 is bridged", q, 8'hA5);
    mem_lat = WIN;
    cmd(1'b0, 16'h1100, 8'h00, c, q);
    chk("R7 ack on last window edge", {c, q}, {2'b00, 8'hA5});
    mem_lat = WIN + 1;
    cmd(1'b0, 16'h1101, 8'h00, c, q);
    chk("R8 ack one past window is late", {c, q}, {2'b00, 8'h00});
    rd_local(16'h00D0, q); chk("R10 late flag set", q[3], 1'b1);
    cmd(1'b1, 16'h00D5, 8'h01, c, q);
  endtask

  task automatic t_late();
    logic [1:0] c; logic [7:0] q; int s0;
    mem_lat = 20;
    cmd(1'b0, 16'h2040, 8'h00, c, q);
    chk("R8 late code OK sel", c, 2'b00); chk("R8 late data", q, 8'h00);
    rd_local(16'h00D0, q); chk("R3 R10 status in background", q, 8'h0C);
    chk("R10 irq raised", irq_late, 1'b1);
    cmd(1'b0, 16'h1234, 8'h00, c, q); chk("R11 read while busy", c, 2'b10);
    cmd(1'b1, 16'h3000, 8'h11, c, q); chk("R11 write while busy", c, 2'b10);
    wait_idle();
    rd_local(16'h00D0, q); chk("R4 R5 status after background", q, 8'h0B);
    rd_local(16'h00D4, q); chk("R5 held data", q, 8'hE5);
    rd_local(16'h00D2, q); chk("R6 last addr low", q, 8'h40);
    rd_local(16'h00D3, q); chk("R6 last addr high", q, 8'h20);
    s0 = mem_starts;
    cmd(1'b0, 16'h2040, 8'h00, c, q);
    chk("R6 held read", {c, q}, {2'b00, 8'hE5});
    repeat (3) @(negedge clk);
    chk("R6 no new fetch", mem_starts, s0);
    rd_local(16'h00D0, q); chk("R4 R5 R10 status after held read", q, 8'h00);
    chk("R10 irq sticky", irq_late, 1'b1);
    cmd(1'b1, 16'h00D5, 8'h00, c, q); chk("R10 write 0 keeps irq", irq_late, 1'b1);
    cmd(1'b1, 16'h00D5, 8'h01, c, q); chk("R10 write 1 clears irq", irq_late, 1'b0);
  endtask

  task automatic t_codes();
    logic [1:0] c; logic [7:0] q;
    mem_lat = 20;
    cmd(1'b1, 16'h00D1, 8'h00, c, q);
    cmd(1'b0, 16'h1500, 8'h00, c, q); chk("R8 sel 00 gives IGNORED", c, 2'b01);
    wait_idle();
    cmd(1'b1, 16'h00D1, 8'h02, c, q);
    cmd(1'b0, 16'h1501, 8'h00, c, q); chk("R8 sel 10 gives FAIL", c, 2'b10);
    wait_idle();
    rd_local(16'h00D4, q); chk("R8 background data kept", q, 8'hA4);
    cmd(1'b1, 16'h00D1, 8'h03, c, q);
    rd_local(16'h00D1, q); chk("R9 reserved code stored as 01", q, 8'h01);
    cmd(1'b0, 16'h1502, 8'h00, c, q); chk("R9 late answer OK", c, 2'b00);
    wait_idle();
  endtask

  task automatic t_write();
    logic [1:0] c; logic [7:0] q;
    mem_lat = 20;
    cmd(1'b1, 16'h3000, 8'h77, c, q);
    chk("R12 write code", c, 2'b00);
    chk("R12 mem write fields", {seen_we, seen_addr, seen_wdata}, {1'b1, 16'h3000, 8'h77});
    rd_local(16'h00D0, q); chk("R3 busy during write", q[2:1], 2'b10);
    wait_idle();
    rd_local(16'h00D0, q); chk("R4 done after write", q[2:1], 2'b01);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; mem_lat = 2;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = 16'h0; cmd_wdata = 8'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local();
    t_direct();
    t_late();
    t_codes();
    t_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule